// File: doc/BRIEF.md
# Serial Multiplexed Converter Front End

This block is the digital serial face of an eleven-input sampling converter. It acts as an SPI mode 0 slave. While chip select is low it takes in a ten-clock frame whose four leading bits pick an input channel. In the same frame it shifts out the result of the conversion that the previous frame asked for. When chip select goes high after a complete frame, the block runs a conversion of the selected channel. A separate converter clock times the conversion, and the block receives that clock as a one-cycle tick. The analog level of every channel arrives as a ten-bit digital value on a flat input bus, so the block is fully synchronous to its system clock.

Results are pipelined by one frame. A host that scans channels A, B, C reads A's value during the frame that requests B, and so on. The first frame after reset returns a placeholder. The serial output is enabled only while the block is selected, so several slaves can share one data line. A busy output marks the conversion window. A frame opened during that window is refused and flagged.

Top module: `serial_adc_front`

## Requirements
- R1: After reset, busy, proto_err, dout_oe and dout are all 0.
- R2: dout_oe is 1 exactly while cs_n is 0, and dout is 0 whenever dout_oe is 0.
- R3: din is sampled on each rising sck while cs_n is low, most significant bit first. The first four bits of a ten-bit frame (frame bits 9..6) form the channel address. The remaining six bits have no effect on the result.
- R4: During a frame, dout presents a ten-bit result, most significant bit first. The first bit is present before the first rising sck, and each later bit appears after a falling sck and before the next rising sck.
- R5: After cs_n falls, dout stays 0 until two conv_tick pulses have been seen with cs_n low.
- R6: The result shifted out in a frame is the conversion requested by the most recent accepted frame. The first frame after reset returns 0.
- R7: When cs_n rises after exactly ten rising sck edges, busy goes high on the next clock. It stays high for exactly 44 conv_tick pulses and falls on the 44th. The channel value is captured at that moment.
- R8: A channel address from 11 to 15 converts to 0x3FF. Addresses 0 to 10 return chan_val bits [10*a+9 : 10*a].
- R9: A frame with a number of rising sck edges other than ten starts no conversion, and busy stays 0. The next frame still returns the previous result.
- R10: If cs_n falls while busy is high, proto_err is 1 from the next clock. That frame's address is discarded, and the running conversion completes normally. proto_err clears when cs_n next falls while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the master, idle low |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data in, address first |
| conv_tick | input | 1 | One-cycle pulse per converter clock period |
| chan_val | input | 110 | Ten-bit level of each of the 11 channels, channel 0 in the low bits |
| dout | output | 1 | Serial data out, 0 when not enabled |
| dout_oe | output | 1 | Output enable for dout |
| busy | output | 1 | Conversion in progress |
| proto_err | output | 1 | A frame was opened during a conversion |

## Verification
The design registers sck and cs_n once and acts on an edge at the first clock that sees it. Each bit taken in or put out therefore settles one system clock after the serial edge. The bench holds every serial phase for four clocks and reads dout just before raising sck.

busy and proto_err are sampled two clocks after cs_n moves, which is one clock after the registered detection. The conversion length is measured by counting conv_tick pulses that fall inside the busy window.

A scoreboard queue holds, for each full frame, the result due one frame later. Each captured word is compared against it.

// File: rtl/serial_adc_front.sv
module serial_adc_front #(
  parameter int NCH         = 11,
  parameter int RES         = 10,
  parameter int FRAME       = 10,
  parameter int ABITS       = 4,
  parameter int CONV_TICKS  = 44,
  parameter int VALID_TICKS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck,
  input  logic               cs_n,
  input  logic               din,
  input  logic               conv_tick,
  input  logic [NCH*RES-1:0] chan_val,
  output logic               dout,
  output logic               dout_oe,
  output logic               busy,
  output logic               proto_err
);
  localparam int BW = $clog2(FRAME + 2);
  localparam int CW = $clog2(CONV_TICKS);
  localparam int VW = $clog2(VALID_TICKS + 1);
  localparam logic [BW-1:0] FRAME_B   = BW'(FRAME);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_TICKS - 1);
  localparam logic [VW-1:0] VALID_B   = VW'(VALID_TICKS);

  logic             sck_q, cs_q;
  logic [FRAME-1:0] in_sr;
  logic [BW-1:0]    bitcnt;
  logic [RES-1:0]   out_sr, result;
  logic [VW-1:0]    vcnt;
  logic [ABITS-1:0] conv_addr;
  logic [CW-1:0]    conv_cnt;

  wire sck_rise = sck & ~sck_q;
  wire sck_fall = ~sck & sck_q;
  wire cs_fall  = ~cs_n & cs_q;
  wire cs_rise  = cs_n & ~cs_q;

  wire             in_range = {1'b0, conv_addr} < (ABITS+1)'(NCH);
  wire [ABITS-1:0] idx      = in_range ? conv_addr : '0;
  wire [RES-1:0]   sel_val  = in_range ? chan_val[int'(idx)*RES +: RES] : '1;

  assign dout_oe = ~cs_n;
  assign dout    = dout_oe & (vcnt == VALID_B) & out_sr[RES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_sr     <= '0;
      bitcnt    <= '0;
      out_sr    <= '0;
      vcnt      <= '0;
      proto_err <= 1'b0;
    end else if (cs_fall) begin
      out_sr    <= result;
      bitcnt    <= '0;
      vcnt      <= '0;
      proto_err <= busy;
    end else if (!cs_n) begin
      if (sck_rise) begin
        in_sr <= {in_sr[FRAME-2:0], din};
        if (bitcnt <= FRAME_B) bitcnt <= bitcnt + 1'b1;
      end
      if (sck_fall) out_sr <= {out_sr[RES-2:0], 1'b0};
      if (conv_tick && vcnt < VALID_B) vcnt <= vcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      conv_cnt  <= '0;
      conv_addr <= '0;
      result    <= '0;
    end else if (cs_rise && bitcnt == FRAME_B && !proto_err && !busy) begin
      busy      <= 1'b1;
      conv_cnt  <= '0;
      conv_addr <= in_sr[FRAME-1 -: ABITS];
    end else if (busy && conv_tick) begin
      if (conv_cnt == CONV_LAST) begin
        busy   <= 1'b0;
        result <= sel_val;
      end else begin
        conv_cnt <= conv_cnt + 1'b1;
      end
    end
  end

  a_r7_busy_from_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_n) && !$past(cs_q));

  a_r9_busy_needs_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bitcnt) == FRAME_B);

  a_r7_busy_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(conv_tick));

  a_r6_result_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(busy));

  a_r10_err_on_busy_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> $past(busy) && $past(cs_q) && !$past(cs_n));

  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dout);
endmodule

// File: tb/serial_adc_front_test.sv
module serial_adc_front_test;
  localparam int NCH = 11;
  localparam int RES = 10;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, din = 0, conv_tick = 0;
  logic [NCH*RES-1:0] chan_val;
  logic dout, dout_oe, busy, proto_err;

  int n_cmp = 0, n_bad = 0, tick_div = 0, ticks_seen = 0;
  logic [RES-1:0] held;
  logic [RES-1:0] expq[$];
  logic [RES-1:0] rx_word;
  string rx_tag;
  event rx_done;

  serial_adc_front uut (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .din(din),
    .conv_tick(conv_tick), .chan_val(chan_val), .dout(dout), .dout_oe(dout_oe),
    .busy(busy), .proto_err(proto_err));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tick_div  <= (tick_div == 3) ? 0 : tick_div + 1;
    conv_tick <= (tick_div == 3);
  end

  always @(posedge clk) if (busy && conv_tick) ticks_seen <= ticks_seen + 1;

  function automatic logic [RES-1:0] mdl(input int a);
    return (a < NCH) ? RES'((a * 93 + 17) & 1023) : '1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(rx_done) begin
    logic [RES-1:0] e;
    e = expq.pop_front();
    check(rx_tag, 32'(rx_word), 32'(e));
  end

  task automatic xfer(input int addr, input int nbits, input string tag);
    logic [9:0] word;
    logic [9:0] rx;
    word = {4'(addr), 6'h2D};
    rx = '0;
    if (nbits == 10) expq.push_back(held);
    @(negedge clk) cs_n = 0;
    repeat (2) @(negedge clk);
    check("R5 dout held low after select", 32'(dout), 0);
    check("R2 output enabled while selected", 32'(dout_oe), 1);
    repeat (12) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      din = word[9-i];
      repeat (3) @(negedge clk);
      if (i < 10) rx[9-i] = dout;
      sck = 1;
      repeat (4) @(negedge clk);
      sck = 0;
      repeat (4) @(negedge clk);
    end
    cs_n = 1;
    ticks_seen = 0;
    repeat (2) @(negedge clk);
    check("R2 output released when deselected", 32'(dout_oe), 0);
    if (nbits == 10) begin
      rx_word = rx;
      rx_tag = tag;
      -> rx_done;
    end
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic good(input int addr, input string tag);
    xfer(addr, 10, tag);
    check("R7 busy after full frame", 32'(busy), 1);
    wait_idle();
    check("R7 conversion spans 44 ticks", 32'(ticks_seen), 44);
    held = mdl(addr);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) chan_val[i*RES +: RES] = mdl(i);
    held = '0;
    repeat (3) @(negedge clk);
    check("R1 busy reset", 32'(busy), 0);
    check("R1 error reset", 32'(proto_err), 0);
    check("R1 enable reset", 32'(dout_oe), 0);
    check("R1 data reset", 32'(dout), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    good(3,  "R6 first frame returns 0");
    good(4,  "R3 R4 ch3 result");
    good(6,  "R4 ch4 result");
    good(10, "R5 R4 ch6 result");
    good(0,  "R8 ch10 result");
    good(12, "R3 ch0 result");
    good(15, "R8 addr12 full scale");
    xfer(2, 5, "");
    check("R9 short frame leaves busy low", 32'(busy), 0);
    repeat (4) @(negedge clk);
    check("R9 still idle", 32'(busy), 0);
    good(1,  "R9 R8 addr15 kept past short frame");
    xfer(5, 10, "R6 ch1 result");
    xfer(7, 10, "R10 refused frame returns old result");
    check("R10 flag set", 32'(proto_err), 1);
    wait_idle();
    held = mdl(5);
    xfer(8, 10, "R10 running conversion kept");
    check("R10 flag cleared", 32'(proto_err), 0);
    wait_idle();
    held = mdl(8);
    good(2,  "R6 ch8 result");
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule